// File: doc/BRIEF.md
# Microcoded Sequencer with Patchable Control Store

This block is a finite-state machine whose behaviour is set by a control store rather than by fixed next-state gates. Each state owns one 16-bit microinstruction. A state register acts as a program counter, and a small sequencer decides each cycle whether to step to the following address, take a conditional branch on one selected input bit, or jump. Output microinstructions load a registered output, which keeps its value for every other instruction type.

Most of the control store is a fixed table (addresses 0 to 47). The top sixteen addresses (48 to 63) are a writable patch memory. A four-entry redirect table can swap any next address for an entry in patch memory, so a faulty state can be replaced without touching the fixed table. Both the patch memory and the redirect table are loaded through one synchronous write port.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 0, the output becomes 0 and every redirect entry becomes invalid; the state at address 0 after reset is never redirected.
- R2: Bits [15:14] of a microinstruction give its type: 00 output (payload in bits [7:0]), 01 branch (select [13:11], polarity [10], target [5:0]), 10 jump (target [5:0]), 11 no-op.
- R3: After an output, a no-op or a branch not taken, the next address is the current address plus one, modulo 64 (47 steps to 48, 63 wraps to 0).
- R4: A branch is taken when `in_vec[select]` equals the polarity bit; the next address is then the target field.
- R5: A jump always makes the target field the next address.
- R6: `out_o` loads the payload at the edge that ends an output microinstruction and holds its value through every other type.
- R7: Addresses 0 to 47 fetch from the fixed table and addresses 48 to 63 fetch patch word (address minus 48).
- R8: A redirect entry is written as bit 15 valid, bits [9:4] match address, bits [3:0] patch index. When the next address (sequential, branch or jump) equals a valid match address, the state instead becomes 48 plus that index in the same cycle; the lowest-numbered matching entry wins; invalid entries never match.
- R9: With `wr_en` high at an edge, `wr_sel` 0 stores `wr_data` into patch word `wr_addr` and `wr_sel` 1 stores it into redirect entry `wr_addr[1:0]`. A patch write is seen by the fetch in the following cycle, and a redirect write does not affect the next address chosen at the edge where it is stored.
- R10: The fixed table holds: 0 output 0x11; 1 branch on bit 0 high to 5; 2 output 0x22; 3 jump to 0; 5 output 0x55; 6 branch on bit 1 low to 0; 7 output 0x77; 8 jump to 8; every other word is a no-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vec | input | 8 | Condition inputs tested by branches |
| wr_en | input | 1 | Write strobe for patch memory or redirect table |
| wr_sel | input | 1 | 0 selects patch memory, 1 selects redirect table |
| wr_addr | input | 4 | Patch word index or redirect entry index |
| wr_data | input | 16 | Microinstruction or redirect entry contents |
| state_o | output | 6 | Current state (control store address) |
| out_o | output | 8 | Registered output |

## Verification
Two pairs of events can meet in one cycle: a redirect entry being written in the very cycle whose next address it would match, and a branch whose taken target is itself a redirect match address. The first is provoked by writing an entry for address 2 while the state is 1; the state must still reach 2 and only the next visit to 2 goes to patch memory. The second is provoked by matching the branch target 5 with the branch condition true, and the state must land directly in patch memory; a patch-word rewrite made just before that word is fetched is judged the same way, by the payload seen on `out_o`.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int INSTR_W = 16;
  localparam int ADDR_W  = 6;
  localparam int SEL_W   = 3;
  localparam int IN_W    = 2 ** SEL_W;
  localparam int PAY_W   = 8;

  typedef enum logic [1:0] {
    OP_OUT = 2'b00,
    OP_BR  = 2'b01,
    OP_JMP = 2'b10,
    OP_NOP = 2'b11
  } op_e;

  typedef struct packed {
    logic [1:0]        op;
    logic [SEL_W-1:0]  sel;
    logic              pol;
    logic [3:0]        spare;
    logic [ADDR_W-1:0] tgt;
  } uinstr_t;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int DEPTH = 48
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [INSTR_W-1:0] word
);

  function automatic logic [INSTR_W-1:0] fixed_word(input logic [ADDR_W-1:0] a);
    logic [INSTR_W-1:0] w;
    w = {OP_NOP, 14'd0};
    case (a)
      6'd0: w = {OP_OUT, 6'd0, 8'h11};
      6'd1: w = {OP_BR, 3'd0, 1'b1, 4'd0, 6'd5};
      6'd2: w = {OP_OUT, 6'd0, 8'h22};
      6'd3: w = {OP_JMP, 8'd0, 6'd0};
      6'd5: w = {OP_OUT, 6'd0, 8'h55};
      6'd6: w = {OP_BR, 3'd1, 1'b0, 4'd0, 6'd0};
      6'd7: w = {OP_OUT, 6'd0, 8'h77};
      6'd8: w = {OP_JMP, 8'd0, 6'd8};
      default: w = {OP_NOP, 14'd0};
    endcase
    return w;
  endfunction

  always_comb begin
    if (addr < ADDR_W'(DEPTH)) word = fixed_word(addr);
    else                       word = {OP_NOP, 14'd0};
  end

endmodule

// File: rtl/useq_patch_ram.sv
module useq_patch_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/useq_redirect.sv
module useq_redirect
  import useq_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 4,
  parameter int BASE    = 48,
  localparam int EIDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [EIDX_W-1:0]   wentry,
  input  logic [INSTR_W-1:0]  wdata,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                hit_o
);

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  match_q [ENTRIES];
  logic [IDX_W-1:0]   idx_q   [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  logic unused_wdata;
  assign unused_wdata = ^wdata[INSTR_W-2:ADDR_W+4];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)                                   valid_q[e] <= 1'b0;
      else if (we && wentry == EIDX_W'(e))       valid_q[e] <= wdata[INSTR_W-1];
    end
    always_ff @(posedge clk) begin
      if (we && wentry == EIDX_W'(e)) begin
        match_q[e] <= wdata[4 +: ADDR_W];
        idx_q[e]   <= wdata[IDX_W-1:0];
      end
    end
    assign hit_vec[e] = valid_q[e] && (match_q[e] == addr_i);
  end

  always_comb begin
    addr_o = addr_i;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hit_vec[e]) addr_o = ADDR_W'(BASE) + ADDR_W'(idx_q[e]);
    end
  end

  assign hit_o = |hit_vec;

  // R1
  rd_clear_chk: assert property (@(posedge clk) rst |=> (valid_q == '0));

endmodule

// File: rtl/useq_nextpc.sv
module useq_nextpc
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] pc,
  input  uinstr_t           cur,
  input  logic [IN_W-1:0]   in_vec,
  output logic [ADDR_W-1:0] nxt
);

  logic cond;
  assign cond = (in_vec[cur.sel] == cur.pol);

  always_comb begin
    nxt = pc + ADDR_W'(1);
    case (cur.op)
      OP_BR:   if (cond) nxt = cur.tgt;
      OP_JMP:  nxt = cur.tgt;
      default: nxt = pc + ADDR_W'(1);
    endcase
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ROM_DEPTH  = 48,
  parameter int RAM_DEPTH  = 16,
  parameter int RD_ENTRIES = 4,
  localparam int RAM_AW    = $clog2(RAM_DEPTH),
  localparam int EIDX_W    = (RD_ENTRIES > 1) ? $clog2(RD_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IN_W-1:0]    in_vec,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [RAM_AW-1:0]  wr_addr,
  input  logic [INSTR_W-1:0] wr_data,
  output logic [ADDR_W-1:0]  state_o,
  output logic [PAY_W-1:0]   out_o
);

  logic [ADDR_W-1:0]  pc_q;
  logic [PAY_W-1:0]   out_q;
  logic [INSTR_W-1:0] rom_word, ram_word, instr_word;
  logic [RAM_AW-1:0]  ram_raddr;
  logic [ADDR_W-1:0]  seq_nxt, final_nxt;
  logic               rd_hit;
  uinstr_t            cur;

  useq_rom #(.DEPTH(ROM_DEPTH)) u_rom (
    .addr (pc_q),
    .word (rom_word)
  );

  assign ram_raddr = RAM_AW'(pc_q - ADDR_W'(ROM_DEPTH));

  useq_patch_ram #(.DEPTH(RAM_DEPTH), .WIDTH(INSTR_W)) u_ram (
    .clk   (clk),
    .we    (wr_en && !wr_sel),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (ram_raddr),
    .rdata (ram_word)
  );

  assign instr_word = (pc_q < ADDR_W'(ROM_DEPTH)) ? rom_word : ram_word;
  assign cur        = uinstr_t'(instr_word);

  useq_nextpc u_nextpc (
    .pc     (pc_q),
    .cur    (cur),
    .in_vec (in_vec),
    .nxt    (seq_nxt)
  );

  useq_redirect #(
    .ENTRIES (RD_ENTRIES),
    .IDX_W   (RAM_AW),
    .BASE    (ROM_DEPTH)
  ) u_redirect (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en && wr_sel),
    .wentry (wr_addr[EIDX_W-1:0]),
    .wdata  (wr_data),
    .addr_i (seq_nxt),
    .addr_o (final_nxt),
    .hit_o  (rd_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      out_q <= '0;
    end else begin
      pc_q <= final_nxt;
      if (cur.op == OP_OUT) out_q <= instr_word[PAY_W-1:0];
    end
  end

  assign state_o = pc_q;
  assign out_o   = out_q;

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (state_o == '0 && out_o == '0));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur.op != OP_OUT) |=> $stable(out_o));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((cur.op == OP_OUT || cur.op == OP_NOP) && !rd_hit) |=> (state_o == $past(state_o) + ADDR_W'(1)));

  // R4
  branch_take_chk: assert property (@(posedge clk) disable iff (rst)
    (cur.op == OP_BR && in_vec[cur.sel] == cur.pol && !rd_hit) |=> (state_o == $past(cur.tgt)));

  // R8
  redirect_land_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (state_o >= ADDR_W'(ROM_DEPTH)));

endmodule

// File: tb/useq_top_tb.sv
module useq_top_tb;

  localparam int CLK_P = 10;
  localparam int NVEC  = 12;
  localparam int WDOG  = 50000;

  // vector: {in_vec, cycles after reset, expected state, expected out}
  localparam logic [29:0] VEC [NVEC] = '{
    {8'h00, 8'd1, 6'd1, 8'h11},
    {8'h00, 8'd2, 6'd2, 8'h11},
    {8'h00, 8'd3, 6'd3, 8'h22},
    {8'h00, 8'd4, 6'd0, 8'h22},
    {8'h01, 8'd2, 6'd5, 8'h11},
    {8'h01, 8'd3, 6'd6, 8'h55},
    {8'h01, 8'd4, 6'd0, 8'h55},
    {8'h03, 8'd4, 6'd7, 8'h55},
    {8'h03, 8'd5, 6'd8, 8'h77},
    {8'h03, 8'd7, 6'd8, 8'h77},
    {8'hFE, 8'd2, 6'd2, 8'h11},
    {8'hFD, 8'd4, 6'd0, 8'h55}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  in_vec;
  logic        wr_en, wr_sel;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [5:0]  state_o;
  logic [7:0]  out_o;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  useq_top u_dut (
    .clk(clk), .rst(rst), .in_vec(in_vec), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .state_o(state_o), .out_o(out_o)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [5:0] exp_pc, input logic [7:0] exp_out);
    n_run = n_run + 1;
    if (state_o !== exp_pc || out_o !== exp_out) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual state=%0d out=%h expected state=%0d out=%h",
               req, state_o, out_o, exp_pc, exp_out);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic wr_ram(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = 1'b0; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wr_rd(input logic [3:0] e, input logic v, input logic [5:0] m, input logic [3:0] idx);
    wr_en = 1'b1; wr_sel = 1'b1; wr_addr = e; wr_data = {v, 5'd0, m, idx};
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_vec = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_addr = '0; wr_data = '0;
    tick();
    // patch memory loaded under reset (R9 write path)
    wr_ram(4'd0,  16'h00A5);
    wr_ram(4'd1,  16'h803F);
    wr_ram(4'd2,  16'h003C);
    wr_ram(4'd3,  16'h8000);
    wr_ram(4'd4,  16'h802F);
    wr_ram(4'd15, 16'hC000);
    do_reset();
    chk("R1 reset state", 6'd0, 8'h00);

    // table walk: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NVEC; i++) begin
      in_vec = VEC[i][29:22];
      do_reset();
      for (int c = 0; c < int'(VEC[i][21:14]); c++) tick();
      chk("R4/R6/R10 vector", VEC[i][13:8], VEC[i][7:0]);
    end

    // R8 redirect of sequential address into patch memory
    in_vec = 8'h00; do_reset();
    wr_rd(4'd0, 1'b1, 6'd2, 4'd0);
    tick(); chk("R8 redirect seq", 6'd48, 8'h11);
    tick(); chk("R7 patch fetch", 6'd49, 8'hA5);
    tick(); chk("R5 jump to 63", 6'd63, 8'hA5);
    tick(); chk("R3 wrap 63 to 0", 6'd0, 8'hA5);

    // R8 redirect of a taken branch target
    in_vec = 8'h01; do_reset();
    wr_rd(4'd1, 1'b1, 6'd5, 4'd2);
    tick(); chk("R8 redirect branch", 6'd50, 8'h11);
    tick(); chk("R8 patch payload", 6'd51, 8'h3C);
    tick(); chk("R5 patch jump", 6'd0, 8'h3C);

    // R3 step from 47 into 48
    in_vec = 8'h00; do_reset();
    wr_rd(4'd0, 1'b1, 6'd2, 4'd4);
    tick(); chk("R8 redirect idx4", 6'd52, 8'h11);
    tick(); chk("R5 jump 47", 6'd47, 8'h11);
    tick(); chk("R3 step 47 to 48", 6'd48, 8'h11);
    tick(); chk("R7 patch word 0", 6'd49, 8'hA5);

    // R8 invalid entry never matches
    do_reset();
    wr_rd(4'd0, 1'b0, 6'd2, 4'd0);
    tick(); chk("R8 invalid entry", 6'd2, 8'h11);

    // R8 lowest entry wins
    do_reset();
    wr_rd(4'd3, 1'b1, 6'd3, 4'd2);
    wr_rd(4'd1, 1'b1, 6'd3, 4'd0);
    tick(); chk("R8 priority", 6'd48, 8'h22);

    // R9 redirect write in the cycle it would match
    do_reset();
    tick();
    wr_rd(4'd0, 1'b1, 6'd2, 4'd0);
    chk("R9 same-cycle redirect", 6'd2, 8'h11);
    tick(); tick(); tick();
    tick(); chk("R9 redirect later", 6'd48, 8'h11);

    // R9 patch write seen by the following fetch
    do_reset();
    wr_rd(4'd0, 1'b1, 6'd2, 4'd0);
    wr_ram(4'd0, 16'h0099);
    chk("R9 patch write state", 6'd48, 8'h11);
    tick(); chk("R9 patch write visible", 6'd49, 8'h99);

    // R1 reset clears redirect entries and output
    do_reset();
    chk("R1 reset after run", 6'd0, 8'h00);
    tick(); tick();
    chk("R1 redirect cleared", 6'd2, 8'h11);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule